// File: doc/BRIEF.md
# Registered-Module SDRAM Command Sequencer

This block drives one rank of SDRAM on a memory module. On that module the command, address, clock-enable and byte-mask lines pass through a one-cycle pipeline register, but the data lines connect straight to the devices. After reset the block brings the devices up. It then refreshes them at a fixed cadence and serves one burst read or burst write at a time through a valid/ready request port. Every access opens a row, issues one column command with auto-precharge, and leaves the bank closed.

A `reg_mode` input selects between registered and unbuffered module timing. In registered mode the devices see every command one cycle after it leaves the block, so the block shifts read-data capture and write-data launch one cycle later. Byte masks travel through the same register as the commands, so they are launched in the command frame. All device spacings are counted between commands at the block's own pins. The pipeline register delays every command by the same amount, so these spacings equal the spacings the devices see. Nanosecond limits are turned into clock counts by ceiling division with a clock-period parameter.

Write data is taken from `wr_data` on every cycle in which `wr_take` is high. Read data is presented on `rd_data` unregistered, on every cycle in which `rd_valid` is high.

Top module: `sdram_seq`

## Requirements
- R1: After reset release, CKE stays low and the command bus (cs_n, ras_n, cas_n, we_n) stays at NOP (0,1,1,1) until the INIT-th rising edge, where INIT = ceil(INIT_NS/CLK_NS). Then the block issues a precharge-all (0,0,1,0 with address bit 10 high) one cycle later, INIT_REFS refreshes (0,0,0,1) spaced by ceil(tRP) and then by ceil(tRC), and a mode load (0,0,0,0) ceil(tRC) after the last refresh. The mode word carries log2(burst length) in bits 2:0, the wrap type in bit 3 (1 = interleaved) and the CAS latency in bits 6:4, with all other bits and the bank zero. req_ready stays low throughout.
- R2: After the mode load, req_ready rises TMRD-1 cycles later, so the next command comes no sooner than TMRD cycles after it.
- R3: A request is accepted on a rising edge where req_valid and req_ready are both high. The next cycle shows activate (0,0,1,1) with the bank (top BA_W address bits) and the row (next ROW_W bits), and req_ready is low.
- R4: The column command follows the activate by max(ceil tRCD, ceil tRAS - BL) cycles for a read and by max(ceil tRCD, ceil tRAS - (BL-1+TWR)) cycles for a write.
- R5: A read is (0,1,0,1) and a write is (0,1,0,0). The column command carries the request bank, the column in the low COL_W address bits and bit 10 high for auto-precharge, with all other address bits zero.
- R6: For a read issued in cycle k, rd_valid is high in exactly cycles k+CL+m through k+CL+m+BL-1, where m = 1 in registered mode and 0 in unbuffered mode. In those cycles rd_data equals dq_in.
- R7: For a write issued in cycle k, dq_oe and wr_take are high in exactly cycles k+m through k+m+BL-1, and dq_out equals wr_data.
- R8: During a write, dqm equals the request's byte mask (bit i = 1 masks byte i) in cycles k through k+BL-1 in both modes. It is zero in every other cycle and during reads.
- R9: After a column command in cycle k, the bus stays at NOP and req_ready rises in cycle k+P-1. P is max(BL+ceil tRP, ceil tRC - read gap) for reads and max(BL-1+TWR+ceil tRP, ceil tRC - write gap) for writes, unless a refresh intervenes. Activates are never closer than ceil(tRC).
- R10: Once the mode load is done, a refresh becomes due every ceil(REF_NS/CLK_NS) cycles. While one is due, req_ready is low. At the next idle point the refresh (0,0,0,1) is issued ahead of any new activate, and req_ready rises ceil(tRC)-1 cycles after it.
- R11: reg_mode is sampled when the column command is issued. A change after that cycle does not move the current burst's data window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_mode | input | 1 | 1 = registered module timing, 0 = unbuffered |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | BA_W+ROW_W+COL_W | {bank, row, column} |
| req_mask | input | DQ_W/8 | Byte mask applied to every write beat |
| req_ready | output | 1 | Request can be accepted this cycle |
| wr_data | input | DQ_W | Write beat, taken when wr_take is high |
| wr_take | output | 1 | Write beat consumed this cycle |
| rd_valid | output | 1 | rd_data carries a read beat |
| rd_data | output | DQ_W | Read beat |
| cke | output | 1 | Clock enable to module |
| cs_n | output | 1 | Chip select |
| ras_n | output | 1 | Row strobe |
| cas_n | output | 1 | Column strobe |
| we_n | output | 1 | Write enable |
| ba | output | BA_W | Bank address |
| addr | output | ROW_W | Multiplexed row/column/mode address |
| dqm | output | DQ_W/8 | Byte masks |
| dq_out | output | DQ_W | Data driven to module |
| dq_oe | output | 1 | Data output enable |
| dq_in | input | DQ_W | Data returned by module |

## Verification
Most internal faults show up at the pins within one access. A wrong wait count moves the column command or the ready rise by a countable number of cycles. A wrong latency selection shifts rd_valid or dq_oe by exactly one cycle in one of the two modes. A stale or lost refresh flag either lets an activate through while ready should be low or breaks the fixed spacing of refreshes during idle, which becomes visible within one refresh period. A miscount in the power-up sequence surfaces before the first request can be accepted, as a wrong refresh count or a shifted mode load.

// File: rtl/sdram_seq.sv
module sdram_seq #(
  parameter int CLK_NS    = 4,
  parameter int INIT_NS   = 100000,
  parameter int REF_NS    = 7800,
  parameter int TRCD_NS   = 20,
  parameter int TRP_NS    = 20,
  parameter int TRAS_NS   = 45,
  parameter int TRC_NS    = 68,
  parameter int TWR_CYC   = 2,
  parameter int TMRD_CYC  = 2,
  parameter int INIT_REFS = 8,
  parameter int CAS_LAT   = 3,
  parameter int BURST     = 4,
  parameter int WRAP_IL   = 0,
  parameter int BA_W      = 2,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int DQ_W      = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_mode,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [BA_W+ROW_W+COL_W-1:0]   req_addr,
  input  logic [DQ_W/8-1:0]             req_mask,
  output logic                          req_ready,
  input  logic [DQ_W-1:0]               wr_data,
  output logic                          wr_take,
  output logic                          rd_valid,
  output logic [DQ_W-1:0]               rd_data,
  output logic                          cke,
  output logic                          cs_n,
  output logic                          ras_n,
  output logic                          cas_n,
  output logic                          we_n,
  output logic [BA_W-1:0]               ba,
  output logic [ROW_W-1:0]              addr,
  output logic [DQ_W/8-1:0]             dqm,
  output logic [DQ_W-1:0]               dq_out,
  output logic                          dq_oe,
  input  logic [DQ_W-1:0]               dq_in
);

  function automatic int cdiv(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int AW      = BA_W + ROW_W + COL_W;
  localparam int MW      = DQ_W / 8;
  localparam int INIT_C  = cdiv(INIT_NS);
  localparam int REF_C   = cdiv(REF_NS);
  localparam int RCD_C   = cdiv(TRCD_NS);
  localparam int RP_C    = cdiv(TRP_NS);
  localparam int RAS_C   = cdiv(TRAS_NS);
  localparam int RC_C    = cdiv(TRC_NS);
  localparam int RD_GAP  = mx(RCD_C, RAS_C - BURST);
  localparam int WR_GAP  = mx(RCD_C, RAS_C - (BURST - 1 + TWR_CYC));
  localparam int RD_POST = mx(BURST + RP_C, RC_C - RD_GAP);
  localparam int WR_POST = mx(BURST - 1 + TWR_CYC + RP_C, RC_C - WR_GAP);
  localparam int GAP_W   = $clog2(INIT_C + RC_C + RD_POST + WR_POST + 2);
  localparam int REF_W   = $clog2(REF_C + 1);
  localparam int NR_W    = $clog2(INIT_REFS + 1);
  localparam int CT_W    = $clog2(CAS_LAT + BURST + 3);

  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD  = 4'b0101,
                         C_WR  = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_MRS = 4'b0000;
  localparam logic [ROW_W-1:0] A10    = ROW_W'(1) << 10;
  localparam logic [ROW_W-1:0] MODE_W = ROW_W'({3'(CAS_LAT), 1'(WRAP_IL), 3'($clog2(BURST))});

  typedef enum logic [2:0] {S_PWR, S_PALL, S_IREF, S_LMR, S_IDLE, S_COL} st_t;

  st_t               st;
  logic [GAP_W-1:0]  gap;
  logic [3:0]        cmd_q;
  logic              cke_q, live, ref_pend, wr_q, col_act, col_wr, reg_q;
  logic [BA_W-1:0]   ba_q;
  logic [ROW_W-1:0]  addr_q;
  logic [COL_W-1:0]  col_q;
  logic [MW-1:0]     mask_q;
  logic [NR_W-1:0]   nref;
  logic [REF_W-1:0]  ref_cnt;
  logic [CT_W-1:0]   col_t, lat;
  logic              in_win;

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign cke    = cke_q;
  assign ba     = ba_q;
  assign addr   = addr_q;
  assign lat    = col_wr ? CT_W'(reg_q) : CT_W'(CAS_LAT) + CT_W'(reg_q);
  assign in_win = col_act && col_t >= lat && col_t < lat + CT_W'(BURST);
  assign rd_valid = in_win && !col_wr;
  assign dq_oe    = in_win && col_wr;
  assign wr_take  = dq_oe;
  assign dq_out   = wr_data;
  assign rd_data  = dq_in;
  assign dqm      = (col_act && col_wr && col_t < CT_W'(BURST)) ? mask_q : '0;
  assign req_ready = (st == S_IDLE) && (gap == '0) && !ref_pend && !col_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_PWR;  gap <= GAP_W'(INIT_C - 1);  cmd_q <= C_NOP;  cke_q <= 1'b0;
      ba_q <= '0;  addr_q <= '0;  col_q <= '0;  mask_q <= '0;  nref <= '0;
      live <= 1'b0;  ref_cnt <= REF_W'(REF_C - 1);  ref_pend <= 1'b0;  wr_q <= 1'b0;
      col_act <= 1'b0;  col_wr <= 1'b0;  col_t <= '0;  reg_q <= 1'b0;
    end else begin
      cmd_q <= C_NOP;
      if (live) ref_cnt <= (ref_cnt == '0) ? REF_W'(REF_C - 1) : ref_cnt - 1'b1;
      if (col_act) begin
        col_t <= col_t + 1'b1;
        if (col_t == lat + CT_W'(BURST - 1)) col_act <= 1'b0;
      end
      if (gap != '0) gap <= gap - 1'b1;
      else begin
        case (st)
          S_PWR:  begin cke_q <= 1'b1; st <= S_PALL; end
          S_PALL: begin
            cmd_q <= C_PRE;  addr_q <= A10;  gap <= GAP_W'(RP_C - 1);
            nref <= '0;  st <= S_IREF;
          end
          S_IREF: begin
            cmd_q <= C_REF;  gap <= GAP_W'(RC_C - 1);  nref <= nref + 1'b1;
            if (nref == NR_W'(INIT_REFS - 1)) st <= S_LMR;
          end
          S_LMR: begin
            cmd_q <= C_MRS;  addr_q <= MODE_W;  ba_q <= '0;
            gap <= GAP_W'(TMRD_CYC - 1);  live <= 1'b1;  st <= S_IDLE;
          end
          S_IDLE: begin
            if (ref_pend) begin
              cmd_q <= C_REF;  gap <= GAP_W'(RC_C - 1);  ref_pend <= 1'b0;
            end else if (req_valid && !col_act) begin
              cmd_q  <= C_ACT;
              ba_q   <= req_addr[AW-1 -: BA_W];
              addr_q <= req_addr[COL_W +: ROW_W];
              col_q  <= req_addr[COL_W-1:0];
              wr_q   <= req_write;
              mask_q <= req_mask;
              gap    <= req_write ? GAP_W'(WR_GAP - 1) : GAP_W'(RD_GAP - 1);
              st     <= S_COL;
            end
          end
          S_COL: begin
            cmd_q   <= wr_q ? C_WR : C_RD;
            addr_q  <= ROW_W'(col_q) | A10;
            gap     <= wr_q ? GAP_W'(WR_POST - 1) : GAP_W'(RD_POST - 1);
            col_act <= 1'b1;  col_t <= '0;  col_wr <= wr_q;  reg_q <= reg_mode;
            st      <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
      if (live && ref_cnt == '0) ref_pend <= 1'b1;
    end
  end

endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk #(
  parameter int RC_C = 17,
  parameter int REFS = 8
) (
  input logic clk,
  input logic rst_n,
  input logic cke,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic a10,
  input logic req_valid,
  input logic req_ready,
  input logic rd_valid,
  input logic dq_oe
);
  logic [3:0]  c;
  logic        is_nop, is_act, is_rd, is_wr, is_ref, is_mrs;
  logic [15:0] act_age;
  logic [7:0]  refs_seen;

  assign c      = {cs_n, ras_n, cas_n, we_n};
  assign is_nop = (c == 4'b0111);
  assign is_act = (c == 4'b0011);
  assign is_rd  = (c == 4'b0101);
  assign is_wr  = (c == 4'b0100);
  assign is_ref = (c == 4'b0001);
  assign is_mrs = (c == 4'b0000);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_age   <= 16'hFFFF;
      refs_seen <= '0;
    end else begin
      if (is_act) act_age <= 16'd1;
      else if (act_age != 16'hFFFF) act_age <= act_age + 16'd1;
      if (is_ref && refs_seen != 8'hFF) refs_seen <= refs_seen + 8'd1;
    end
  end

  p_cke_low_nop_r1: assert property (@(posedge clk) disable iff (!rst_n) !cke |-> is_nop);
  p_init_refs_r1:   assert property (@(posedge clk) disable iff (!rst_n) is_mrs |-> refs_seen >= 8'(REFS));
  p_mrs_hold_r2:    assert property (@(posedge clk) disable iff (!rst_n) is_mrs |=> is_nop);
  p_accept_act_r3:  assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> is_act);
  p_col_autopre_r5: assert property (@(posedge clk) disable iff (!rst_n) (is_rd || is_wr) |-> a10);
  p_bus_dir_r6:     assert property (@(posedge clk) disable iff (!rst_n) !(rd_valid && dq_oe));
  p_act_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n) is_act |-> act_age >= 16'(RC_C));
endmodule

bind sdram_seq sdram_seq_chk #(.RC_C(RC_C), .REFS(INIT_REFS)) chk_i (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .a10(addr[10]), .req_valid(req_valid), .req_ready(req_ready),
  .rd_valid(rd_valid), .dq_oe(dq_oe)
);

// File: tb/sdram_seq_tb_top.sv
module sdram_seq_tb_top;
  localparam int CLK_NS = 4, INIT_NS = 400, REF_NS = 2000;
  localparam int TRCD = 20, TRP = 20, TRAS = 45, TRC = 68, TWR = 2, TMRD = 2;
  localparam int NREF = 8, CL = 3, BL = 4, WRAP = 1;
  localparam int BA_W = 2, ROW_W = 13, COL_W = 10, DQ_W = 32, MW = DQ_W / 8;
  localparam int AW = BA_W + ROW_W + COL_W;

  function automatic int cdiv(input int ns); return (ns + CLK_NS - 1) / CLK_NS; endfunction
  function automatic int mx(input int a, input int b); return (a > b) ? a : b; endfunction

  localparam int E_INIT = cdiv(INIT_NS), E_REF = cdiv(REF_NS);
  localparam int E_RCD = cdiv(TRCD), E_RP = cdiv(TRP), E_RAS = cdiv(TRAS), E_RC = cdiv(TRC);
  localparam int E_RDG = mx(E_RCD, E_RAS - BL);
  localparam int E_WRG = mx(E_RCD, E_RAS - (BL - 1 + TWR));
  localparam int E_RDP = mx(BL + E_RP, E_RC - E_RDG);
  localparam int E_WRP = mx(BL - 1 + TWR + E_RP, E_RC - E_WRG);

  localparam logic [3:0] K_NOP = 4'b0111, K_ACT = 4'b0011, K_RD = 4'b0101, K_WR = 4'b0100,
                         K_PRE = 4'b0010, K_REF = 4'b0001, K_MRS = 4'b0000;

  logic clk = 1'b0, rst_n = 1'b0, reg_mode = 1'b1, req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [MW-1:0] req_mask = '0;
  logic [DQ_W-1:0] wr_data = '0, dq_in = '0;
  logic req_ready, wr_take, rd_valid, cke, cs_n, ras_n, cas_n, we_n, dq_oe;
  logic [DQ_W-1:0] rd_data, dq_out;
  logic [BA_W-1:0] ba;
  logic [ROW_W-1:0] addr;
  logic [MW-1:0] dqm;

  always #2 clk = ~clk;

  sdram_seq #(.CLK_NS(CLK_NS), .INIT_NS(INIT_NS), .REF_NS(REF_NS), .TRCD_NS(TRCD),
    .TRP_NS(TRP), .TRAS_NS(TRAS), .TRC_NS(TRC), .TWR_CYC(TWR), .TMRD_CYC(TMRD),
    .INIT_REFS(NREF), .CAS_LAT(CL), .BURST(BL), .WRAP_IL(WRAP), .BA_W(BA_W),
    .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_mode(reg_mode), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_mask(req_mask), .req_ready(req_ready),
    .wr_data(wr_data), .wr_take(wr_take), .rd_valid(rd_valid), .rd_data(rd_data),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba),
    .addr(addr), .dqm(dqm), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));

  int total = 0, bad = 0, ref_viol = 0;
  bit mon_on = 0, prev_rdy = 0;

  function automatic logic [3:0] cmdv();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  function automatic logic [DQ_W-1:0] pat(input logic [AW-1:0] a, input int j);
    return DQ_W'(a) * 32'h9E37_79B1 ^ DQ_W'(j * 32'h0101_0101);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // R10: a refresh after initialisation always follows a cycle with req_ready low
  always @(negedge clk) begin
    if (mon_on && cmdv() == K_REF && prev_rdy) ref_viol++;
    prev_rdy = req_ready;
  end

  task automatic wait_cmd(output logic [3:0] c, output int d, output bit rdy_seen);
    d = 0; rdy_seen = 0;
    forever begin
      @(negedge clk);
      d++;
      if (req_ready) rdy_seen = 1;
      if (cmdv() != K_NOP || d > 4000) break;
    end
    c = cmdv();
  endtask

  task automatic check_init();
    int zeros = 0, d, bad_sp = 0;
    bit nop_ok = 1, rdy_any = 0, r;
    logic [3:0] c;
    forever begin
      @(negedge clk);
      if (cke || zeros > 10000) break;
      zeros++;
      if (cmdv() != K_NOP) nop_ok = 0;
      if (req_ready) rdy_any = 1;
    end
    chk(zeros + 1 == E_INIT, "R1", "cke low cycles", zeros + 1, E_INIT);
    chk(nop_ok, "R1", "nop while cke low", 0, 1);
    wait_cmd(c, d, r); rdy_any |= r;
    chk(c == K_PRE && d == 1 && addr[10], "R1", "precharge-all", {c, 4'(d)}, {K_PRE, 4'd1});
    for (int i = 0; i < NREF; i++) begin
      wait_cmd(c, d, r); rdy_any |= r;
      if (c != K_REF || d != ((i == 0) ? E_RP : E_RC)) bad_sp++;
    end
    chk(bad_sp == 0, "R1", "init refresh spacing errors", bad_sp, 0);
    wait_cmd(c, d, r); rdy_any |= r;
    chk(c == K_MRS && d == E_RC, "R1", "mode load cmd/spacing", {c, 8'(d)}, {K_MRS, 8'(E_RC)});
    chk(addr == ROW_W'({3'(CL), 1'(WRAP), 3'($clog2(BL))}) && ba == '0, "R1", "mode word",
        {ba, addr}, {2'b00, ROW_W'({3'(CL), 1'(WRAP), 3'($clog2(BL))})});
    chk(!rdy_any && !req_ready, "R1", "ready during init", 1, 0);
    d = 0;
    forever begin
      @(negedge clk);
      d++;
      if (req_ready || d > 100) break;
      if (cmdv() != K_NOP) bad_sp++;
    end
    chk(d == TMRD - 1 && bad_sp == 0, "R2", "ready after mode load", d, TMRD - 1);
    mon_on = 1;
  endtask

  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [MW-1:0] m,
                       input bit rm);
    int g = 0, d = 0, lat, rdy_at = -1, e_win = 0, e_mask = 0, e_bus = 0;
    bit ref_saw = 0, inw;
    logic [MW-1:0] em;
    reg_mode = rm; req_write = wr; req_addr = a; req_mask = m; req_valid = 1'b1;
    while (!req_ready && g < 3000) begin @(negedge clk); g++; end
    @(negedge clk);
    req_valid = 1'b0;
    chk(cmdv() == K_ACT && ba == a[AW-1 -: BA_W] && addr == a[COL_W +: ROW_W] && !req_ready,
        "R3", "activate", {cmdv(), ba, addr}, {K_ACT, a[AW-1 -: BA_W], a[COL_W +: ROW_W]});
    forever begin
      @(negedge clk);
      d++;
      if (cmdv() != K_NOP || d > 100) break;
    end
    chk(d == (wr ? E_WRG : E_RDG), "R4", "activate-to-column", d, wr ? E_WRG : E_RDG);
    chk(cmdv() == (wr ? K_WR : K_RD) && ba == a[AW-1 -: BA_W] &&
        addr == (ROW_W'(a[COL_W-1:0]) | (ROW_W'(1) << 10)), "R5", "column command",
        {cmdv(), ba, addr}, {wr ? K_WR : K_RD, a[AW-1 -: BA_W], ROW_W'(a[COL_W-1:0]) | (ROW_W'(1) << 10)});
    reg_mode = !rm;
    lat = wr ? int'(rm) : CL + int'(rm);
    for (int j = 0; j < 60; j++) begin
      if (j > 0) @(negedge clk);
      dq_in = pat(a, j);
      wr_data = ~pat(a, j);
      #1;
      inw = (j >= lat) && (j < lat + BL);
      if (wr) begin
        if (dq_oe != inw || wr_take != inw || rd_valid || (inw && dq_out != ~pat(a, j))) e_win++;
      end else begin
        if (rd_valid != inw || dq_oe || (inw && rd_data != pat(a, j))) e_win++;
      end
      em = (wr && j < BL) ? m : '0;
      if (dqm != em) e_mask++;
      if (cmdv() == K_REF) ref_saw = 1;
      else if (j > 0 && rdy_at < 0 && cmdv() != K_NOP) e_bus++;
      if (rdy_at < 0 && req_ready) rdy_at = j;
      if (rdy_at >= 0 && j >= lat + BL + 1) break;
    end
    if (wr) chk(e_win == 0, "R7 R11", "write data window errors", e_win, 0);
    else    chk(e_win == 0, "R6 R11", "read data window errors", e_win, 0);
    chk(e_mask == 0, "R8", "byte mask errors", e_mask, 0);
    chk(e_bus == 0, "R9", "bus activity after column", e_bus, 0);
    if (!ref_saw)
      chk(rdy_at == (wr ? E_WRP : E_RDP) - 1, "R9", "column-to-ready", rdy_at, (wr ? E_WRP : E_RDP) - 1);
    dq_in = '0;
  endtask

  task automatic check_refresh();
    int d = 0, rdy_at = -1;
    req_valid = 1'b0;
    forever begin
      @(negedge clk);
      d++;
      if (cmdv() == K_REF || d > 3 * E_REF) break;
    end
    chk(cmdv() == K_REF && !req_ready, "R10", "idle refresh seen, ready low", cmdv(), K_REF);
    d = 0;
    forever begin
      @(negedge clk);
      d++;
      if (rdy_at < 0 && req_ready) rdy_at = d;
      if (cmdv() == K_REF || d > 3 * E_REF) break;
    end
    chk(rdy_at == E_RC - 1, "R10", "refresh-to-ready", rdy_at, E_RC - 1);
    chk(d == E_REF, "R10", "refresh period", d, E_REF);
  endtask

  initial begin
    logic [AW-1:0] a;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    chk(!cke && cmdv() == K_NOP && !req_ready && !rd_valid && !dq_oe && dqm == '0,
        "R1", "reset state", {cke, cmdv(), req_ready}, {1'b0, K_NOP, 1'b0});
    rst_n = 1'b1;
    check_init();
    do_op(1'b0, '0, '0, 1'b1);
    do_op(1'b0, '1, '0, 1'b0);
    do_op(1'b1, '1, 4'b0000, 1'b1);
    do_op(1'b1, AW'(25'h0A5_5A5), 4'b1010, 1'b0);
    do_op(1'b1, '0, 4'b1111, 1'b1);
    check_refresh();
    for (int i = 0; i < 40; i++) begin
      a = AW'($urandom());
      do_op(1'($urandom()), a, MW'($urandom()), 1'($urandom()));
    end
    chk(ref_viol == 0, "R10", "refresh issued while ready high", ref_viol, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    summary();
    $finish;
  end
endmodule